// File: doc/BRIEF.md
# Optical Black Clamp Controller

This block is the digital half of a black-level servo for an image sensor readout chain. On every pixel clock it receives one converted sample and a window strobe that marks the optically shielded (dark) pixels at the start of each line. While the strobe is high it measures how far each dark sample sits from a programmable black target, scales that error down and integrates it into a saturating accumulator. The filtered result is turned into an 8-bit offset code for the DAC that trims the converter input.

The code is committed only at the end of a dark window, and only on lines chosen by a line-skip setting. Between commits the code does not move. When the loop enable is low the integrator freezes and the target value itself is passed to the DAC, so the path serves as a plain programmable offset. A synchronous reset parks the DAC at mid-scale.

Top module: `obclamp_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and line counter clear and `dac_code_o` becomes 8'h80 after that edge.
- R2: The error is the 13-bit signed value ({`target_i`, 4'b0000}) minus `sample_i`; the accumulator changes only at edges where `window_i` and `loop_en_i` are both high, and samples outside the window have no effect on `dac_code_o`.
- R3: At each such edge the accumulator (16-bit signed) adds the error shifted right arithmetically by SHIFT_K (default 3), saturating at +32767 and -32768 instead of wrapping.
- R4: The commit happens at the first edge where `window_i` is sampled low after being high; at that edge `dac_code_o` takes 128 + floor(acc / 256), i.e. the accumulator's top 8 bits with the sign bit inverted.
- R5: A line counter advances at every window falling edge, loop enabled or not; with skip value S on `skip_i`, a commit is taken when the counter is 0 and the counter runs 0..S, so S = 0 commits every line and S = 2 commits one line in three.
- R6: With `loop_en_i` low, `dac_code_o` takes `target_i` at every edge, the accumulator holds its value and no commit from the accumulator occurs.
- R7: With `loop_en_i` high, `dac_code_o` does not change at any edge other than a selected commit edge.
- R8: Windows of any length of one pixel or more are integrated and committed in the same way as long windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_i | input | 12 | Converted pixel sample, unsigned |
| window_i | input | 1 | High on shielded dark pixels of the line |
| loop_en_i | input | 1 | 1 = servo loop active, 0 = fixed offset from target |
| target_i | input | 8 | Black-level target register value |
| skip_i | input | 4 | Line-skip value S (commit one line in S+1) |
| dac_code_o | output | 8 | Offset code for the DAC |

## Verification
The hardest states to reach are the two accumulator rails, since each window pixel moves the integrator by at most about 512 counts; the stimulus drives windows of 80 and 160 pixels with the target at one extreme and the sample at the other so that both saturation limits are hit and held for many pixels. The line-skip selection is exercised by a run of lines with S = 2 following lines with S = 0, where only every third window end may move the code. A disabled stretch with a full window inside it checks that the frozen accumulator later commits unchanged.

// File: rtl/obc_pkg.sv
package obc_pkg;
   localparam int unsigned OBC_CODE_W = 8;
   localparam logic [OBC_CODE_W-1:0] OBC_MID_CODE = 8'h80;
endpackage

// File: rtl/obc_err_scale.sv
module obc_err_scale #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned SHIFT_K  = 3
) (
   input  logic [SAMPLE_W-1:0]      sample_i,
   input  logic [CODE_W-1:0]        target_i,
   output logic signed [SAMPLE_W:0] step_o
);
   localparam int unsigned PAD   = SAMPLE_W - CODE_W;
   localparam int unsigned ERR_W = SAMPLE_W + 1;

   logic signed [ERR_W-1:0] tgt_al;
   logic signed [ERR_W-1:0] smp_ext;
   logic signed [ERR_W-1:0] err;

   assign tgt_al  = {1'b0, target_i, {PAD{1'b0}}};
   assign smp_ext = {1'b0, sample_i};
   assign err     = tgt_al - smp_ext;

   generate
      if (SHIFT_K == 0) begin : g_noshift
         assign step_o = err;
      end else begin : g_shift
         assign step_o = err >>> SHIFT_K;
      end
   endgenerate
endmodule

// File: rtl/obc_accum.sv
module obc_accum #(
   parameter int unsigned ACC_W = 16,
   parameter int unsigned IN_W  = 13
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    add_en,
   input  logic signed [IN_W-1:0]  step_i,
   output logic signed [ACC_W-1:0] acc_o
);
   localparam int unsigned SUM_W = ACC_W + 1;
   localparam int unsigned EXT   = SUM_W - IN_W;

   logic signed [ACC_W-1:0] acc_q;
   logic signed [SUM_W-1:0] sum;
   logic signed [ACC_W-1:0] acc_sat;
   logic signed [ACC_W-1:0] pos_rail;
   logic signed [ACC_W-1:0] neg_rail;

   assign pos_rail = {1'b0, {(ACC_W-1){1'b1}}};
   assign neg_rail = {1'b1, {(ACC_W-1){1'b0}}};
   assign sum = {acc_q[ACC_W-1], acc_q} + {{EXT{step_i[IN_W-1]}}, step_i};

   always_comb begin
      if (sum[SUM_W-1] != sum[SUM_W-2]) begin
         acc_sat = sum[SUM_W-1] ? neg_rail : pos_rail;
      end else begin
         acc_sat = sum[ACC_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
      end else if (add_en) begin
         acc_q <= acc_sat;
      end
   end

   assign acc_o = acc_q;
endmodule

// File: rtl/obc_line_sel.sv
module obc_line_sel #(
   parameter int unsigned SKIP_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  logic [SKIP_W-1:0] skip_i,
   output logic              sel_o
);
   logic [SKIP_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         if (cnt_q >= skip_i) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign sel_o = (cnt_q == '0);
endmodule

// File: rtl/obclamp_ctrl.sv
module obclamp_ctrl #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned CODE_W   = obc_pkg::OBC_CODE_W,
   parameter int unsigned ACC_W    = 16,
   parameter int unsigned SHIFT_K  = 3,
   parameter int unsigned SKIP_W   = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                window_i,
   input  logic                loop_en_i,
   input  logic [CODE_W-1:0]   target_i,
   input  logic [SKIP_W-1:0]   skip_i,
   output logic [CODE_W-1:0]   dac_code_o
);
   localparam int unsigned ERR_W = SAMPLE_W + 1;

   generate
      if (SAMPLE_W <= CODE_W) begin : g_bad_width
         $error("obclamp_ctrl: SAMPLE_W must exceed CODE_W");
      end
      if (ACC_W < ERR_W || ACC_W < CODE_W) begin : g_bad_acc
         $error("obclamp_ctrl: ACC_W too narrow");
      end
      if (SHIFT_K > 7) begin : g_bad_shift
         $error("obclamp_ctrl: SHIFT_K must fit in 3 bits");
      end
   endgenerate

   logic                    win_q;
   logic                    win_fall;
   logic                    line_sel;
   logic signed [ERR_W-1:0] step;
   logic signed [ACC_W-1:0] acc_q;
   logic [CODE_W-1:0]       acc_code;
   logic [CODE_W-1:0]       dac_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q <= 1'b0;
      end else begin
         win_q <= window_i;
      end
   end

   assign win_fall = win_q & ~window_i;

   obc_err_scale #(
      .SAMPLE_W(SAMPLE_W),
      .CODE_W  (CODE_W),
      .SHIFT_K (SHIFT_K)
   ) err_i (
      .sample_i(sample_i),
      .target_i(target_i),
      .step_o  (step)
   );

   obc_accum #(
      .ACC_W(ACC_W),
      .IN_W (ERR_W)
   ) acc_i (
      .clk   (clk),
      .rst   (rst),
      .add_en(window_i & loop_en_i),
      .step_i(step),
      .acc_o (acc_q)
   );

   obc_line_sel #(
      .SKIP_W(SKIP_W)
   ) sel_i (
      .clk   (clk),
      .rst   (rst),
      .tick_i(win_fall),
      .skip_i(skip_i),
      .sel_o (line_sel)
   );

   assign acc_code = {~acc_q[ACC_W-1], acc_q[ACC_W-2 -: CODE_W-1]};

   always_ff @(posedge clk) begin
      if (rst) begin
         dac_q <= obc_pkg::OBC_MID_CODE;
      end else if (!loop_en_i) begin
         dac_q <= target_i;
      end else if (win_fall && line_sel) begin
         dac_q <= acc_code;
      end
   end

   assign dac_code_o = dac_q;
endmodule

// File: rtl/obclamp_ctrl_chk.sv
module obclamp_ctrl_chk #(
   parameter int unsigned SAMPLE_W = 12,
   parameter int unsigned CODE_W   = 8,
   parameter int unsigned ACC_W    = 16
) (
   input logic                    clk,
   input logic                    rst,
   input logic [SAMPLE_W-1:0]     sample_i,
   input logic                    window_i,
   input logic                    loop_en_i,
   input logic [CODE_W-1:0]       target_i,
   input logic [CODE_W-1:0]       dac_code_o,
   input logic signed [ACC_W-1:0] acc
);
   localparam int unsigned PAD = SAMPLE_W - CODE_W;

   logic seen_win;
   always_ff @(posedge clk) begin
      if (rst) seen_win <= 1'b0;
      else     seen_win <= window_i;
   end

   logic tgt_ge;
   assign tgt_ge = ({target_i, {PAD{1'b0}}} >= sample_i);

   assert_reset_mid_R1: assert property (@(posedge clk)
      rst |=> dac_code_o == 8'h80);

   assert_idle_acc_R2: assert property (@(posedge clk) disable iff (rst)
      !(window_i && loop_en_i) |=> $stable(acc));

   assert_rise_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (window_i && loop_en_i && tgt_ge) |=> acc >= $past(acc));

   assert_fall_no_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (window_i && loop_en_i && !tgt_ge) |=> acc <= $past(acc));

   assert_fixed_offset_R6: assert property (@(posedge clk) disable iff (rst)
      !loop_en_i |=> dac_code_o == $past(target_i));

   assert_hold_code_R7: assert property (@(posedge clk) disable iff (rst)
      (loop_en_i && !(seen_win && !window_i)) |=> $stable(dac_code_o));
endmodule

bind obclamp_ctrl obclamp_ctrl_chk #(
   .SAMPLE_W(SAMPLE_W),
   .CODE_W  (CODE_W),
   .ACC_W   (ACC_W)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .sample_i  (sample_i),
   .window_i  (window_i),
   .loop_en_i (loop_en_i),
   .target_i  (target_i),
   .dac_code_o(dac_code_o),
   .acc       (acc_q)
);

// File: tb/obclamp_ctrl_tb_top.sv
module obclamp_ctrl_tb_top;
   localparam int K = 3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [11:0] sample = '0;
   logic        window = 1'b0;
   logic        loop_en = 1'b0;
   logic [7:0]  target = '0;
   logic [3:0]  skip = '0;
   logic [7:0]  dac;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   string cur_req = "R1";

   // reference model state
   int m_acc = 0;
   int m_cnt = 0;
   int m_winq = 0;
   int m_dac = 128;

   always #2.5 clk = ~clk;

   obclamp_ctrl dut_i (
      .clk       (clk),
      .rst       (rst),
      .sample_i  (sample),
      .window_i  (window),
      .loop_en_i (loop_en),
      .target_i  (target),
      .skip_i    (skip),
      .dac_code_o(dac)
   );

   always @(posedge clk) begin
      if (rst) begin
         m_acc = 0; m_cnt = 0; m_winq = 0; m_dac = 128;
      end else begin
         bit fall;
         bit sel;
         fall = (m_winq != 0) && !window;
         sel = (m_cnt == 0);
         if (fall) m_cnt = (m_cnt >= int'(skip)) ? 0 : m_cnt + 1;
         if (!loop_en) m_dac = int'(target);
         else if (fall && sel) m_dac = 128 + (m_acc >>> 8);
         if (window && loop_en) begin
            int e;
            e = int'(target) * 16 - int'(sample);
            m_acc = m_acc + (e >>> K);
            if (m_acc > 32767) m_acc = 32767;
            if (m_acc < -32768) m_acc = -32768;
         end
         m_winq = window ? 1 : 0;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (int'(dac) != m_dac) begin
            failures++;
            $display("FAIL %s cycle compare: dac actual=%0d expected=%0d", cur_req, dac, m_dac);
         end
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run(int n, bit w, int s);
      repeat (n) begin
         @(negedge clk);
         window = w;
         sample = 12'(s);
      end
   endtask

   task automatic line(int nwin, int s);
      run(4, 0, 4095);
      run(nwin, 1, s);
      run(6, 0, 0);
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      target = 8'd77;
      run(4, 0, 0);
      @(negedge clk);
      check("R1 reset mid-scale", int'(dac), 128);
      loop_en = 1'b1;
      target = 8'd64;
      @(negedge clk); rst = 1'b0;
      run(3, 0, 0);
      check("R1 after release", int'(dac), 128);

      // R2/R3/R4: samples below target raise the code: 24 * (256>>>3) = 768 -> 131
      cur_req = "R4";
      line(24, 768);
      check("R4 commit code", int'(dac), 131);
      // R2: wild samples outside window ignored
      cur_req = "R2";
      run(10, 0, 4095);
      run(10, 0, 0);
      check("R2 outside window no effect", int'(dac), 131);
      // R3: samples above target bring it back: acc 0 -> 128
      cur_req = "R3";
      line(24, 1280);
      check("R3 integrate negative", int'(dac), 128);

      // R6: disabled -> target passthrough, acc frozen
      cur_req = "R6";
      loop_en = 1'b0;
      target = 8'd10; run(2, 0, 0);
      check("R6 passthrough 10", int'(dac), 10);
      target = 8'd200; run(2, 0, 0);
      check("R6 passthrough 200", int'(dac), 200);
      line(30, 0);
      check("R6 window ignored when off", int'(dac), 200);
      loop_en = 1'b1;
      target = 8'd64;
      line(8, 1024);
      check("R6 acc held while off", int'(dac), 128);

      // R3: saturation at both rails
      cur_req = "R3";
      target = 8'd255;
      line(80, 0);
      check("R3 positive rail", int'(dac), 255);
      target = 8'd0;
      line(160, 4095);
      check("R3 negative rail", int'(dac), 0);

      // R5: skip = 2, one commit every three lines
      cur_req = "R5";
      target = 8'd64;
      skip = 4'd2;
      for (int i = 0; i < 7; i++) line(20, 512);
      check("R5 skip commit", int'(dac), m_dac);
      skip = 4'd0;

      // R8: short windows
      cur_req = "R8";
      line(1, 0);
      line(3, 4000);
      line(2, 100);
      check("R8 short windows", int'(dac), m_dac);

      // R7: long idle, code held
      cur_req = "R7";
      begin
         int held;
         held = int'(dac);
         run(40, 0, 1234);
         check("R7 hold between commits", int'(dac), held);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule